// File: doc/BRIEF.md
# Predicated Vector Multiply-Add Unit

This block decodes and executes one instruction family: integer multiply-accumulate and multiply-subtract on a fixed-length vector. Each call takes a 32-bit instruction word and three source vectors that the surrounding register file has already read. The first source is the current contents of the destination register. The second is the register named by bits 9-5. The third is the register named by bits 20-16. A per-byte predicate vector is the fourth input.

The block returns the register indices to read in the same cycle. It returns the write-back index, the merged result vector, a write enable and an illegal-encoding flag, either combinationally or one cycle later through an optional output register.

One encoding bit picks the operand roles. In the accumulator form, the destination also supplies the addend. In the multiplicand form, the destination also supplies the first factor, and the bits 9-5 register supplies the addend. Element width is picked at run time from 8, 16, 32 or 64 bits. Lanes whose predicate is clear keep the old destination value.

Top module: `vmad_unit`

## Requirements
- R1: A word belongs to the group only if bits 31-24 equal 8'h04 and bit 21 is 0. Any other word presented with `in_valid` raises `illegal` with `wr_en` low.
- R2: Bits 15-14 select the form: 2'b01 is the accumulator form and 2'b11 is the multiplicand form. The values 2'b00 and 2'b10 raise `illegal` with `wr_en` low.
- R3: Bits 23-22 select the lane width for every operand: 2'b00 gives 8-bit lanes, 2'b01 gives 16-bit, 2'b10 gives 32-bit and 2'b11 gives 64-bit.
- R4: Bit 13 set subtracts the product from the addend. Bit 13 clear adds it.
- R5: The accumulator form gives lane = dst + b*m, where `b` is `src_b` and `m` is `src_m`. With bit 13 set it gives dst - b*m.
- R6: The multiplicand form gives lane = b + dst*m. With bit 13 set it gives b - dst*m.
- R7: Predication merges. A lane whose lowest byte has its `pred` bit at 0 outputs the old `src_dst` lane unchanged.
- R8: The product and the sum wrap modulo 2^width. Only the low half of the product is kept, so the result is the same for signed and unsigned operands.
- R9: The read and write indices come from fixed fields. Bits 4-0 give `rd_dst_idx` and `dst_idx`, bits 9-5 give `rd_b_idx`, bits 20-16 give `rd_m_idx` and bits 12-10 give `pg_idx`.
- R10: Word 32'h0401DFE0 decodes as a multiplicand-form add on 8-bit lanes with destination 0, predicate 7, m register 1 and addend register 31. Word 32'h041F5C20 decodes as an accumulator-form add on 8-bit lanes with destination 0, predicate 7, b register 1 and m register 31.
- R11: With the output register on, `wr_en`, `illegal`, `dst_idx` and `result` show the inputs of the previous clock. Both flags are low for a cycle that had `in_valid` low.
- R12: During reset, `wr_en`, `illegal`, `dst_idx` and `result` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | An instruction is presented this cycle |
| instr | input | 32 | Instruction word |
| src_dst | input | VLEN | Current destination register contents |
| src_b | input | VLEN | Register named by bits 9-5 (multiplicand or addend) |
| src_m | input | VLEN | Register named by bits 20-16 (second multiplicand) |
| pred | input | VLEN/8 | Governing predicate, one bit per byte |
| rd_dst_idx | output | 5 | Destination read index |
| rd_b_idx | output | 5 | Second source read index |
| rd_m_idx | output | 5 | Third source read index |
| pg_idx | output | 3 | Predicate register index |
| wr_en | output | 1 | Write result to `dst_idx` |
| illegal | output | 1 | Encoding is outside the group |
| dst_idx | output | 5 | Write-back register index |
| result | output | VLEN | Merged result vector |

## Verification
The four read indices are combinational, so the bench checks them one time step after it drives a word, before the next clock edge. With the default output register, the flags, write index and result are due at the first rising edge after the inputs are driven. The bench drives on falling edges and keeps a queue of expected values from its own lane-by-lane model. At each falling edge it pops and compares the entry for the word driven one cycle earlier, so every comparison lands exactly one register stage after its stimulus.

// File: rtl/vmad_pkg.sv
package vmad_pkg;

  typedef enum logic [1:0] {
    EW8  = 2'b00,
    EW16 = 2'b01,
    EW32 = 2'b10,
    EW64 = 2'b11
  } elem_w_e;

  typedef struct packed {
    logic    legal;
    logic    mad_form;
    logic    negate;
    elem_w_e ew;
    logic [4:0] dst;
    logic [4:0] srcb;
    logic [4:0] zm;
    logic [2:0] pg;
  } vmad_op_t;

  localparam logic [7:0] GROUP_TAG = 8'h04;

  // Wrapping multiply-accumulate; callers keep the low lane-width bits.
  function automatic logic [63:0] lane_mac(input logic [63:0] addend,
                                           input logic [63:0] f1,
                                           input logic [63:0] f2,
                                           input logic        negate);
    logic [63:0] prod;
    prod = f1 * f2;
    return negate ? (addend - prod) : (addend + prod);
  endfunction

endpackage

// File: rtl/vmad_decode.sv
module vmad_decode
  import vmad_pkg::*;
(
  input  logic [31:0] instr,
  output vmad_op_t    op
);
  logic group_hit;
  logic form_ok;

  assign group_hit = (instr[31:24] == GROUP_TAG) && !instr[21];
  assign form_ok   = instr[14];

  always_comb begin
    op.legal    = group_hit && form_ok;
    op.mad_form = instr[15];
    op.negate   = instr[13];
    op.ew       = elem_w_e'(instr[23:22]);
    op.dst      = instr[4:0];
    op.srcb     = instr[9:5];
    op.zm       = instr[20:16];
    op.pg       = instr[12:10];
  end
endmodule

// File: rtl/vmad_lanes.sv
module vmad_lanes
  import vmad_pkg::*;
#(
  parameter  int VLEN  = 128,
  parameter  int EW    = 8,
  localparam int LANES = VLEN / EW
) (
  input  logic [VLEN-1:0]  dst_v,
  input  logic [VLEN-1:0]  srcb_v,
  input  logic [VLEN-1:0]  zm_v,
  input  logic [LANES-1:0] act,
  input  logic             mad_form,
  input  logic             negate,
  output logic [VLEN-1:0]  res_v
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [EW-1:0] old_v;
    logic [EW-1:0] b_v;
    logic [EW-1:0] m_v;
    logic [EW-1:0] addend;
    logic [EW-1:0] fac;
    logic [EW-1:0] calc;

    assign old_v  = dst_v[g*EW +: EW];
    assign b_v    = srcb_v[g*EW +: EW];
    assign m_v    = zm_v[g*EW +: EW];
    assign addend = mad_form ? b_v : old_v;
    assign fac    = mad_form ? old_v : b_v;
    assign calc   = EW'(lane_mac(64'(addend), 64'(fac), 64'(m_v), negate));
    assign res_v[g*EW +: EW] = act[g] ? calc : old_v;
  end
endmodule

// File: rtl/vmad_unit.sv
module vmad_unit
  import vmad_pkg::*;
#(
  parameter  int VLEN    = 128,
  parameter  bit OUT_REG = 1'b1,
  localparam int NBYTES  = VLEN / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [31:0]       instr,
  input  logic [VLEN-1:0]   src_dst,
  input  logic [VLEN-1:0]   src_b,
  input  logic [VLEN-1:0]   src_m,
  input  logic [NBYTES-1:0] pred,
  output logic [4:0]        rd_dst_idx,
  output logic [4:0]        rd_b_idx,
  output logic [4:0]        rd_m_idx,
  output logic [2:0]        pg_idx,
  output logic              wr_en,
  output logic              illegal,
  output logic [4:0]        dst_idx,
  output logic [VLEN-1:0]   result
);
  vmad_op_t op;
  logic [VLEN-1:0] lane_res [4];
  logic [VLEN-1:0] res_c;
  logic            wr_c;
  logic            ill_c;

  vmad_decode u_dec (.instr(instr), .op(op));

  assign rd_dst_idx = op.dst;
  assign rd_b_idx   = op.srcb;
  assign rd_m_idx   = op.zm;
  assign pg_idx     = op.pg;

  for (genvar gw = 0; gw < 4; gw++) begin : g_width
    localparam int EW  = 8 << gw;
    localparam int LN  = VLEN / EW;
    localparam int BPL = EW / 8;
    logic [LN-1:0] lane_act;
    for (genvar l = 0; l < LN; l++) begin : g_act
      assign lane_act[l] = pred[l*BPL];
    end
    vmad_lanes #(.VLEN(VLEN), .EW(EW)) u_lanes (
      .dst_v   (src_dst),
      .srcb_v  (src_b),
      .zm_v    (src_m),
      .act     (lane_act),
      .mad_form(op.mad_form),
      .negate  (op.negate),
      .res_v   (lane_res[gw])
    );
  end

  assign res_c = lane_res[op.ew];
  assign wr_c  = in_valid && op.legal;
  assign ill_c = in_valid && !op.legal;

  // R7
  merge_lane0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op.legal && !pred[0]) |-> (res_c[7:0] == src_dst[7:0]));

  if (OUT_REG) begin : g_oreg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        wr_en   <= 1'b0;
        illegal <= 1'b0;
        dst_idx <= '0;
        result  <= '0;
      end else begin
        wr_en   <= wr_c;
        illegal <= ill_c;
        dst_idx <= op.dst;
        result  <= res_c;
      end
    end

    // R11
    out_follows_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en || illegal) |-> $past(in_valid));
    // R1
    write_group_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (($past(instr[31:24]) == 8'h04) && !$past(instr[21])));
    // R2
    write_form_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> $past(instr[14]));
    // R9
    write_dst_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (dst_idx == $past(instr[4:0])));
    // R1
    flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && illegal));
  end else begin : g_comb
    assign wr_en   = wr_c;
    assign illegal = ill_c;
    assign dst_idx = op.dst;
    assign result  = res_c;
  end
endmodule

// File: tb/vmad_unit_tb.sv
`timescale 1ns/1ps
module vmad_unit_tb_top;
  localparam int VLEN = 128;
  localparam int NB   = VLEN / 8;

  typedef struct packed {
    logic            we;
    logic            ill;
    logic [4:0]      dst;
    logic [VLEN-1:0] res;
  } exp_t;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            in_valid;
  logic [31:0]     instr;
  logic [VLEN-1:0] src_dst, src_b, src_m;
  logic [NB-1:0]   pred;
  logic [4:0]      rd_dst_idx, rd_b_idx, rd_m_idx, dst_idx;
  logic [2:0]      pg_idx;
  logic            wr_en, illegal;
  logic [VLEN-1:0] result;

  int checks = 0;
  int failures = 0;
  exp_t  exp_q[$];
  string tag_q[$];

  always #2.5 clk = ~clk;

  vmad_unit #(.VLEN(VLEN), .OUT_REG(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
    .src_dst(src_dst), .src_b(src_b), .src_m(src_m), .pred(pred),
    .rd_dst_idx(rd_dst_idx), .rd_b_idx(rd_b_idx), .rd_m_idx(rd_m_idx),
    .pg_idx(pg_idx), .wr_en(wr_en), .illegal(illegal),
    .dst_idx(dst_idx), .result(result)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [VLEN-1:0] act, input logic [VLEN-1:0] expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, expv);
    end
  endtask

  function automatic logic [31:0] mk(input logic [1:0] ew, input logic [1:0] form,
      input logic neg, input logic [4:0] zm, input logic [2:0] pg,
      input logic [4:0] b, input logic [4:0] d);
    return {8'h04, ew, 1'b0, zm, form, neg, pg, b, d};
  endfunction

  function automatic logic [VLEN-1:0] rvec();
    logic [VLEN-1:0] v;
    for (int i = 0; i < VLEN / 32; i++) v[i*32 +: 32] = $urandom;
    return v;
  endfunction

  // Behavioural model: byte-assembled lanes, 64-bit arithmetic, masked.
  function automatic exp_t model(input logic [31:0] w, input logic [VLEN-1:0] d,
      input logic [VLEN-1:0] b, input logic [VLEN-1:0] m, input logic [NB-1:0] p);
    exp_t e;
    int nbytes;
    longint unsigned mask;
    bit ok;
    ok = (w[31:24] == 8'h04) && (w[21] == 1'b0) &&
         (w[15:14] == 2'b01 || w[15:14] == 2'b11);
    e.we = ok; e.ill = !ok; e.dst = w[4:0]; e.res = '0;
    nbytes = 1 << w[23:22];
    mask = (nbytes == 8) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << (8 * nbytes)) - 1);
    for (int ln = 0; ln < NB / nbytes; ln++) begin
      longint unsigned dv = 0, bv = 0, mv = 0, r, add, fac;
      for (int k = 0; k < nbytes; k++) begin
        dv |= longint'(d[(ln*nbytes+k)*8 +: 8]) << (8*k);
        bv |= longint'(b[(ln*nbytes+k)*8 +: 8]) << (8*k);
        mv |= longint'(m[(ln*nbytes+k)*8 +: 8]) << (8*k);
      end
      if (w[15]) begin add = bv; fac = dv; end
      else       begin add = dv; fac = bv; end
      r = w[13] ? (add - fac * mv) : (add + fac * mv);
      r &= mask;
      if (!p[ln*nbytes]) r = dv;
      for (int k = 0; k < nbytes; k++) e.res[(ln*nbytes+k)*8 +: 8] = r[8*k +: 8];
    end
    return e;
  endfunction

  task automatic compare_pending();
    exp_t e;
    string t;
    if (exp_q.size() == 0) return;
    e = exp_q.pop_front();
    t = tag_q.pop_front();
    chk(wr_en === e.we, t, "wr_en", VLEN'(wr_en), VLEN'(e.we));
    chk(illegal === e.ill, t, "illegal", VLEN'(illegal), VLEN'(e.ill));
    if (e.we) begin
      chk(dst_idx === e.dst, t, "dst_idx", VLEN'(dst_idx), VLEN'(e.dst));
      chk(result === e.res, t, "result", result, e.res);
    end
  endtask

  task automatic step(input logic v, input logic [31:0] w, input logic [VLEN-1:0] d,
      input logic [VLEN-1:0] b, input logic [VLEN-1:0] m, input logic [NB-1:0] p,
      input string tag);
    exp_t e;
    @(negedge clk);
    compare_pending();
    in_valid = v; instr = w; src_dst = d; src_b = b; src_m = m; pred = p;
    e = model(w, d, b, m, p);
    if (!v) begin e.we = 1'b0; e.ill = 1'b0; end
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  task automatic chk_idx(input logic [4:0] d, input logic [4:0] b,
                         input logic [4:0] m, input logic [2:0] p, input string tag);
    #1;
    chk(rd_dst_idx === d, tag, "rd_dst_idx", VLEN'(rd_dst_idx), VLEN'(d));
    chk(rd_b_idx === b, tag, "rd_b_idx", VLEN'(rd_b_idx), VLEN'(b));
    chk(rd_m_idx === m, tag, "rd_m_idx", VLEN'(rd_m_idx), VLEN'(m));
    chk(pg_idx === p, tag, "pg_idx", VLEN'(pg_idx), VLEN'(p));
  endtask

  bit done = 1'b0;

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [VLEN-1:0] a, b, m, d;
    logic [NB-1:0] all1;
    all1 = '1;
    rst_n = 1'b0; in_valid = 1'b0; instr = '0;
    src_dst = '0; src_b = '0; src_m = '0; pred = '0;
    repeat (3) @(negedge clk);
    // R12 reset state
    chk(wr_en === 1'b0 && illegal === 1'b0, "R12", "flags", VLEN'({wr_en, illegal}), '0);
    chk(dst_idx === 5'd0 && result === '0, "R12", "data", result, '0);
    rst_n = 1'b1;

    // R10 known words, R9 fields
    d = rvec(); b = rvec(); m = rvec();
    step(1'b1, 32'h0401DFE0, d, b, m, all1, "R10 R6");
    chk_idx(5'd0, 5'd31, 5'd1, 3'd7, "R10 R9");
    step(1'b1, 32'h041F5C20, d, b, m, all1, "R10 R5");
    chk_idx(5'd0, 5'd1, 5'd31, 3'd7, "R10 R9");
    step(1'b1, mk(2'b10, 2'b01, 1'b1, 5'd19, 3'd2, 5'd6, 5'd27), d, b, m, all1, "R9");
    chk_idx(5'd27, 5'd6, 5'd19, 3'd2, "R9");

    // R3 R4 R5 R6: every width, form and operation
    for (int ew = 0; ew < 4; ew++)
      for (int f = 0; f < 2; f++)
        for (int n = 0; n < 2; n++) begin
          a = rvec(); b = rvec(); m = rvec();
          step(1'b1, mk(2'(ew), f ? 2'b11 : 2'b01, 1'(n), 5'(ew*3+1), 3'(n+f),
                        5'(f+4), 5'(ew*8+f*2+n)), a, b, m, all1,
               f ? "R6 R3 R4" : "R5 R3 R4");
        end

    // R7 merging under several predicate patterns
    for (int ew = 0; ew < 4; ew++) begin
      a = rvec(); b = rvec(); m = rvec();
      step(1'b1, mk(2'(ew), 2'b01, 1'b0, 5'd2, 3'd1, 5'd3, 5'd4), a, b, m,
           16'h5555, "R7");
      step(1'b1, mk(2'(ew), 2'b11, 1'b1, 5'd2, 3'd1, 5'd3, 5'd4), a, b, m,
           16'h0000, "R7");
      step(1'b1, mk(2'(ew), 2'b11, 1'b0, 5'd2, 3'd1, 5'd3, 5'd4), a, b, m,
           16'($urandom), "R7");
      step(1'b1, mk(2'(ew), 2'b01, 1'b1, 5'd2, 3'd1, 5'd3, 5'd4), a, b, m,
           16'hAAAA, "R7");
    end

    // R8 wrap-around extremes
    for (int ew = 0; ew < 4; ew++) begin
      step(1'b1, mk(2'(ew), 2'b01, 1'b0, 5'd1, 3'd0, 5'd2, 5'd3),
           '1, '1, '1, all1, "R8");
      step(1'b1, mk(2'(ew), 2'b11, 1'b1, 5'd1, 3'd0, 5'd2, 5'd3),
           {NB{8'h80}}, '0, {NB{8'h80}}, all1, "R8");
    end

    // R1 R2 illegal encodings
    d = rvec();
    step(1'b1, {8'h05, 24'h01DFE0}, d, b, m, all1, "R1");
    step(1'b1, 32'h0421DFE0, d, b, m, all1, "R1");
    step(1'b1, 32'hFFFFFFFF, d, b, m, all1, "R1");
    step(1'b1, mk(2'b01, 2'b00, 1'b0, 5'd1, 3'd1, 5'd1, 5'd1), d, b, m, all1, "R2");
    step(1'b1, mk(2'b10, 2'b10, 1'b1, 5'd1, 3'd1, 5'd1, 5'd1), d, b, m, all1, "R2");

    // R11 idle cycles between live ones
    step(1'b0, 32'h0401DFE0, d, b, m, all1, "R11");
    step(1'b1, 32'h041F5C20, d, b, m, all1, "R11");
    step(1'b0, 32'h05000000, d, b, m, all1, "R11");
    step(1'b0, 32'h0, d, b, m, all1, "R11");

    @(negedge clk);
    compare_pending();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule